// File: doc/BRIEF.md
# Packet Match-and-Count Classifier

The block watches a byte stream of packets, one byte per cycle while `in_valid` is high, with `in_sop` marking the first byte and `in_eop` the last. For every ordinary packet it keeps a running packet total and byte total. It also checks each packet against three small match tables in parallel. The first table holds source addresses, the second holds destination ports, and the third holds 32-bit whole-packet fingerprints. Each table entry has its own hit counter.

The source address and the destination port are compared as soon as their last header byte arrives. The fingerprint is folded over every byte of the packet and is compared once the end marker has been seen. All counters are updated in the cycle after the end byte.

Packets sent to a reserved destination port are control packets. They are never counted. Instead they add a table entry, remove a table entry, or request a dump. A dump streams every counter out of a read port, one word per cycle. Software fills the tables this way, in-band, and reads statistics the same way.

Top module: `pkt_classifier`

## Requirements
- R1: After reset all counters read zero, all table entries are empty, and `rd_valid` and `rd_last` are low.
- R2: Every packet that is not a control packet adds 1 to the packet total and adds its byte count (number of bytes from sop to eop inclusive) to the byte total. Both totals are visible one cycle after the eop byte is accepted.
- R3: The fingerprint starts at 5381. For each byte b it becomes fp*33 + b modulo 2^32. If the final value equals a valid fingerprint entry, that entry's counter increments.
- R4: Bytes 0..3 form the source address, most significant byte first. A packet whose address equals a valid address entry increments that entry's counter.
- R5: Bytes 6..7 form the destination port, most significant byte first. A matching packet increments that port entry's counter. A packet shorter than 8 bytes never produces a port hit.
- R6: A packet is a control packet when its destination port equals `CMD_PORT` (default 0xFFFF). Its opcode is byte 28 and its 32-bit operand is bytes 29..32, big-endian. A port operand uses the low 16 bits. A control packet is not counted anywhere, and one shorter than 33 bytes has no effect.
- R7: Opcodes 0x01, 0x03 and 0x05 add the operand to the address, port and fingerprint table. The entry goes into the lowest-numbered empty slot with its counter at zero. Adding a key that is already present, or adding to a full table, changes nothing.
- R8: Opcodes 0x02, 0x04 and 0x06 remove the matching entry from the address, port and fingerprint table and clear its counter. A packet carrying that key no longer scores. Removing an absent key changes nothing.
- R9: Opcode 0x07 starts a dump of 2+3*N_ENT words on consecutive cycles, starting one cycle after the command's eop. The order is: packet total, byte total, address slots 0..N-1, port slots 0..N-1, fingerprint slots 0..N-1. `rd_last` is high with the final word only.
- R10: Packets sent back to back, with the next sop in the cycle right after an eop, are each classified and counted on their own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte present on `in_data` |
| in_sop | input | 1 | First byte of a packet |
| in_eop | input | 1 | Last byte of a packet |
| in_data | input | 8 | Packet byte |
| rd_valid | output | 1 | Dump word present |
| rd_last | output | 1 | Final dump word |
| rd_data | output | CNT_W | Dump word |

## Verification
Two situations are hardest to reach from the ports. The first is a table that is full and holds entries in every slot. The second is a slot freed by a delete and then reused by a later add. Both exist only after a specific sequence of control packets, and slot placement can only be seen through the position of a counter in the dump stream. The stimulus therefore fills the address table with eight distinct keys, offers a ninth and a duplicate, deletes one entry, and re-adds a new key. Each step is followed by traffic aimed at individual slots and by a full dump. Back-to-back packets that carry no idle cycle are driven separately, to show that latched header hits do not leak between neighbouring packets.

// File: rtl/pkt_cls_pkg.sv
package pkt_cls_pkg;

    localparam logic [31:0] FP_SEED = 32'd5381;

    // byte offsets within a packet
    localparam int OFS_SRC_LAST   = 3;
    localparam int OFS_DPORT_HI   = 6;
    localparam int OFS_DPORT_LAST = 7;
    localparam int OFS_OPCODE     = 28;
    localparam int OFS_OPER_FIRST = 29;
    localparam int OFS_OPER_LAST  = 32;

    typedef enum logic [7:0] {
        OP_ADD_SRC   = 8'h01,
        OP_DEL_SRC   = 8'h02,
        OP_ADD_DPORT = 8'h03,
        OP_DEL_DPORT = 8'h04,
        OP_ADD_FP    = 8'h05,
        OP_DEL_FP    = 8'h06,
        OP_DUMP      = 8'h07
    } cls_op_e;

    typedef enum logic [1:0] {
        EDIT_NONE = 2'd0,
        EDIT_ADD  = 2'd1,
        EDIT_DEL  = 2'd2
    } edit_e;

    // what the parser knows once a packet has ended
    typedef struct packed {
        logic [31:0] fp;
        logic [7:0]  opcode;
        logic [31:0] operand;
        logic [15:0] len;
        logic        is_cmd;
        logic        cmd_full;
    } pkt_summary_t;

    function automatic logic [31:0] fp_step(input logic [31:0] h, input logic [7:0] b);
        return (h << 5) + h + {24'd0, b};
    endfunction

    function automatic edit_e op_to_edit(input logic go, input logic [7:0] op,
                                         input cls_op_e add_op, input cls_op_e del_op);
        if (go && op == add_op) return EDIT_ADD;
        if (go && op == del_op) return EDIT_DEL;
        return EDIT_NONE;
    endfunction

endpackage

// File: rtl/pkt_field_parse.sv
module pkt_field_parse
    import pkt_cls_pkg::*;
#(
    parameter int          IDX_W    = 16,
    parameter logic [15:0] CMD_PORT = 16'hFFFF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic         in_sop,
    input  logic         in_eop,
    input  logic [7:0]   in_data,
    output logic         pkt_start,
    output logic         src_stb,
    output logic [31:0]  src_key,
    output logic         dport_stb,
    output logic [15:0]  dport_key,
    output logic         done,
    output pkt_summary_t summ
);

    logic [IDX_W-1:0] idx_q, cur_idx, nxt_idx;
    logic [31:0]      src_q, fp_q, oper_q;
    logic [15:0]      dport_q, len_q;
    logic [7:0]       op_q;
    logic             is_cmd_q, done_q;

    assign cur_idx   = in_sop ? '0 : idx_q;
    assign nxt_idx   = (&cur_idx) ? cur_idx : cur_idx + 1'b1;
    assign pkt_start = in_valid && in_sop;

    assign src_stb   = in_valid && (cur_idx == IDX_W'(OFS_SRC_LAST));
    assign src_key   = {src_q[23:0], in_data};
    assign dport_stb = in_valid && (cur_idx == IDX_W'(OFS_DPORT_LAST));
    assign dport_key = {dport_q[7:0], in_data};

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q    <= '0;
            src_q    <= '0;
            fp_q     <= FP_SEED;
            oper_q   <= '0;
            dport_q  <= '0;
            len_q    <= '0;
            op_q     <= '0;
            is_cmd_q <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= in_valid && in_eop;
            if (in_valid) begin
                idx_q <= nxt_idx;
                len_q <= 16'(nxt_idx);
                fp_q  <= fp_step(in_sop ? FP_SEED : fp_q, in_data);
                if (cur_idx <= IDX_W'(OFS_SRC_LAST))
                    src_q <= {src_q[23:0], in_data};
                if (cur_idx == IDX_W'(OFS_DPORT_HI) || cur_idx == IDX_W'(OFS_DPORT_LAST))
                    dport_q <= {dport_q[7:0], in_data};
                if (in_sop)
                    is_cmd_q <= 1'b0;
                else if (cur_idx == IDX_W'(OFS_DPORT_LAST))
                    is_cmd_q <= (dport_key == CMD_PORT);
                if (in_sop)
                    op_q <= '0;
                else if (cur_idx == IDX_W'(OFS_OPCODE))
                    op_q <= in_data;
                if (in_sop)
                    oper_q <= '0;
                else if (cur_idx >= IDX_W'(OFS_OPER_FIRST) && cur_idx <= IDX_W'(OFS_OPER_LAST))
                    oper_q <= {oper_q[23:0], in_data};
            end
        end
    end

    assign done          = done_q;
    assign summ.fp       = fp_q;
    assign summ.opcode   = op_q;
    assign summ.operand  = oper_q;
    assign summ.len      = len_q;
    assign summ.is_cmd   = is_cmd_q;
    assign summ.cmd_full = (len_q >= 16'(OFS_OPER_LAST + 1));

    // a finished packet always holds at least one byte
    p_len_nonzero_r2: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (len_q != 16'd0));
    // control flag only after the destination port was fully seen
    p_cmd_hdr_r6: assert property (@(posedge clk) disable iff (rst)
        is_cmd_q |-> (len_q >= 16'(OFS_DPORT_LAST + 1)));

endmodule

// File: rtl/match_table.sv
module match_table
    import pkt_cls_pkg::*;
#(
    parameter int N     = 8,
    parameter int KW    = 32,
    parameter int CW    = 32,
    parameter bit EARLY = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic                 lk_stb,
    input  logic [KW-1:0]        lk_key,
    input  logic                 commit,
    input  edit_e                edit_kind,
    input  logic [KW-1:0]        edit_key,
    output logic [N-1:0][CW-1:0] cnt
);

    logic [N-1:0][KW-1:0] key_q;
    logic [N-1:0][CW-1:0] cnt_q;
    logic [N-1:0]         valid_q;
    logic [N-1:0]         cmp, use_hit, edit_hit, add_sel;
    logic                 exists, any_free;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            cmp[i]      = valid_q[i] && (key_q[i] == lk_key);
            edit_hit[i] = valid_q[i] && (key_q[i] == edit_key);
        end
    end

    // lowest empty slot
    always_comb begin
        add_sel  = '0;
        any_free = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (!valid_q[i] && !any_free) begin
                add_sel[i] = 1'b1;
                any_free   = 1'b1;
            end
        end
    end
    assign exists = |edit_hit;

    generate
        if (EARLY) begin : g_early
            logic [N-1:0] hit_q;
            always_ff @(posedge clk) begin
                if (rst)
                    hit_q <= '0;
                else if (lk_stb)
                    hit_q <= cmp;
                else if (clr)
                    hit_q <= '0;
            end
            assign use_hit = hit_q;
        end else begin : g_late
            logic unused_clr_w;
            assign unused_clr_w = clr;
            assign use_hit      = cmp & {N{lk_stb}};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            key_q   <= '0;
            cnt_q   <= '0;
            valid_q <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (edit_kind == EDIT_DEL && edit_hit[i]) begin
                    valid_q[i] <= 1'b0;
                    cnt_q[i]   <= '0;
                end else if (edit_kind == EDIT_ADD && !exists && any_free && add_sel[i]) begin
                    valid_q[i] <= 1'b1;
                    key_q[i]   <= edit_key;
                    cnt_q[i]   <= '0;
                end else if (commit && use_hit[i] && valid_q[i]) begin
                    cnt_q[i] <= cnt_q[i] + 1'b1;
                end
            end
        end
    end

    assign cnt = cnt_q;

    generate
        for (genvar i = 0; i < N; i++) begin : g_chk
            // an entry moves by one hit or returns to zero on edit
            p_cnt_step_r8: assert property (@(posedge clk) disable iff (rst)
                (cnt_q[i] != $past(cnt_q[i])) |->
                    ((cnt_q[i] == $past(cnt_q[i]) + 1'b1) || (cnt_q[i] == '0)));
            // an empty slot never carries a count
            p_empty_zero_r8: assert property (@(posedge clk) disable iff (rst)
                !valid_q[i] |-> (cnt_q[i] == '0));
            for (genvar j = i + 1; j < N; j++) begin : g_pair
                // no key is held twice
                p_no_dup_r7: assert property (@(posedge clk) disable iff (rst)
                    (valid_q[i] && valid_q[j]) |-> (key_q[i] != key_q[j]));
            end
        end
    endgenerate

endmodule

// File: rtl/pkt_classifier.sv
module pkt_classifier
    import pkt_cls_pkg::*;
#(
    parameter int          N_ENT    = 8,
    parameter int          CNT_W    = 32,
    parameter logic [15:0] CMD_PORT = 16'hFFFF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_sop,
    input  logic             in_eop,
    input  logic [7:0]       in_data,
    output logic             rd_valid,
    output logic             rd_last,
    output logic [CNT_W-1:0] rd_data
);

    localparam int NWORDS = 2 + 3 * N_ENT;
    localparam int IW     = $clog2(NWORDS);
    localparam logic [IW-1:0] LAST_IDX = IW'(NWORDS - 1);

    logic         pkt_start, src_stb, dport_stb, done;
    logic [31:0]  src_key;
    logic [15:0]  dport_key;
    pkt_summary_t summ;

    pkt_field_parse #(.IDX_W(16), .CMD_PORT(CMD_PORT)) u_parse (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop), .in_data(in_data),
        .pkt_start(pkt_start),
        .src_stb(src_stb), .src_key(src_key),
        .dport_stb(dport_stb), .dport_key(dport_key),
        .done(done), .summ(summ)
    );

    logic  stat_commit, cmd_go;
    edit_e src_edit, dport_edit, fp_edit;

    assign stat_commit = done && !summ.is_cmd;
    assign cmd_go      = done && summ.is_cmd && summ.cmd_full;
    assign src_edit    = op_to_edit(cmd_go, summ.opcode, OP_ADD_SRC, OP_DEL_SRC);
    assign dport_edit  = op_to_edit(cmd_go, summ.opcode, OP_ADD_DPORT, OP_DEL_DPORT);
    assign fp_edit     = op_to_edit(cmd_go, summ.opcode, OP_ADD_FP, OP_DEL_FP);

    logic [N_ENT-1:0][CNT_W-1:0] src_cnt, dport_cnt, fp_cnt;

    match_table #(.N(N_ENT), .KW(32), .CW(CNT_W), .EARLY(1'b1)) u_src_tab (
        .clk(clk), .rst(rst), .clr(pkt_start),
        .lk_stb(src_stb), .lk_key(src_key), .commit(stat_commit),
        .edit_kind(src_edit), .edit_key(summ.operand), .cnt(src_cnt)
    );

    match_table #(.N(N_ENT), .KW(16), .CW(CNT_W), .EARLY(1'b1)) u_dport_tab (
        .clk(clk), .rst(rst), .clr(pkt_start),
        .lk_stb(dport_stb), .lk_key(dport_key), .commit(stat_commit),
        .edit_kind(dport_edit), .edit_key(summ.operand[15:0]), .cnt(dport_cnt)
    );

    match_table #(.N(N_ENT), .KW(32), .CW(CNT_W), .EARLY(1'b0)) u_fp_tab (
        .clk(clk), .rst(rst), .clr(1'b0),
        .lk_stb(done), .lk_key(summ.fp), .commit(stat_commit),
        .edit_kind(fp_edit), .edit_key(summ.operand), .cnt(fp_cnt)
    );

    // global totals
    logic [CNT_W-1:0] pkt_cnt_q, byte_cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pkt_cnt_q  <= '0;
            byte_cnt_q <= '0;
        end else if (stat_commit) begin
            pkt_cnt_q  <= pkt_cnt_q + 1'b1;
            byte_cnt_q <= byte_cnt_q + CNT_W'(summ.len);
        end
    end

    // dump sequencer
    logic          dump_on_q;
    logic [IW-1:0] dump_idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dump_on_q  <= 1'b0;
            dump_idx_q <= '0;
        end else if (dump_on_q) begin
            if (dump_idx_q == LAST_IDX) begin
                dump_on_q  <= 1'b0;
                dump_idx_q <= '0;
            end else begin
                dump_idx_q <= dump_idx_q + 1'b1;
            end
        end else if (cmd_go && summ.opcode == OP_DUMP) begin
            dump_on_q  <= 1'b1;
            dump_idx_q <= '0;
        end
    end

    always_comb begin
        rd_data = '0;
        if (dump_idx_q == IW'(0)) rd_data = pkt_cnt_q;
        if (dump_idx_q == IW'(1)) rd_data = byte_cnt_q;
        for (int i = 0; i < N_ENT; i++) begin
            if (dump_idx_q == IW'(2 + i))             rd_data = src_cnt[i];
            if (dump_idx_q == IW'(2 + N_ENT + i))     rd_data = dport_cnt[i];
            if (dump_idx_q == IW'(2 + 2 * N_ENT + i)) rd_data = fp_cnt[i];
        end
    end

    assign rd_valid = dump_on_q;
    assign rd_last  = dump_on_q && (dump_idx_q == LAST_IDX);

    p_last_in_dump_r9: assert property (@(posedge clk) disable iff (rst)
        rd_last |-> rd_valid);
    p_dump_ends_last_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(rd_valid) |-> $past(rd_last));
    p_cmd_not_counted_r6: assert property (@(posedge clk) disable iff (rst)
        (done && summ.is_cmd) |=> ($stable(pkt_cnt_q) && $stable(byte_cnt_q)));
    p_pkt_step_r2: assert property (@(posedge clk) disable iff (rst)
        (pkt_cnt_q != $past(pkt_cnt_q)) |-> (pkt_cnt_q == $past(pkt_cnt_q) + 1'b1));

endmodule

// File: tb/pkt_classifier_tb.sv
module pkt_classifier_tb_top;

    localparam int          N_ENT  = 8;
    localparam int          NWORDS = 2 + 3 * N_ENT;
    localparam logic [15:0] CPORT  = 16'hFFFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic [7:0]  in_data = '0;
    logic        rd_valid, rd_last;
    logic [31:0] rd_data;

    always #2 clk = ~clk;  // 250 MHz

    pkt_classifier #(.N_ENT(N_ENT), .CNT_W(32), .CMD_PORT(CPORT)) dut_i (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop), .in_data(in_data),
        .rd_valid(rd_valid), .rd_last(rd_last), .rd_data(rd_data)
    );

    int n_checks = 0;
    int n_errors = 0;
    logic [7:0]  pb [0:63];
    int          plen;
    logic [31:0] exp_w [0:NWORDS-1];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [31:0] fp_of();
        logic [31:0] h = 32'd5381;
        for (int i = 0; i < plen; i++) h = h * 33 + {24'd0, pb[i]};
        return h;
    endfunction

    task automatic mk_pkt(input logic [31:0] src, input logic [15:0] dp, input int pay);
        plen = 28 + pay;
        for (int i = 0; i < 64; i++) pb[i] = 8'(i * 7 + 3);
        pb[0] = src[31:24]; pb[1] = src[23:16]; pb[2] = src[15:8]; pb[3] = src[7:0];
        pb[4] = 8'h12; pb[5] = 8'h34;
        pb[6] = dp[15:8]; pb[7] = dp[7:0];
        pb[8] = 8'(plen >> 8); pb[9] = 8'(plen);
    endtask

    task automatic mk_cmd(input logic [7:0] op, input logic [31:0] arg);
        mk_pkt(32'h0A000001, CPORT, 5);
        pb[28] = op;
        pb[29] = arg[31:24]; pb[30] = arg[23:16]; pb[31] = arg[15:8]; pb[32] = arg[7:0];
    endtask

    task automatic send(input int idle, input bit hold);
        for (int i = 0; i < plen; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_sop   = (i == 0);
            in_eop   = (i == plen - 1);
            in_data  = pb[i];
        end
        if (!hold) begin
            @(negedge clk);
            in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
            repeat (idle) @(negedge clk);
        end
    endtask

    task automatic cmd(input logic [7:0] op, input logic [31:0] arg);
        mk_cmd(op, arg);
        send(3, 1'b0);
    endtask

    task automatic pkt(input logic [31:0] src, input logic [15:0] dp, input int pay);
        mk_pkt(src, dp, pay);
        send(3, 1'b0);
        exp_w[0] += 1;
        exp_w[1] += 32'(28 + pay);
    endtask

    function automatic string word_req(input int k);
        if (k < 2) return "R2";
        if (k < 2 + N_ENT) return "R4";
        if (k < 2 + 2 * N_ENT) return "R5";
        return "R3";
    endfunction

    // issue the dump command and compare the whole stream (R9)
    task automatic dump_check(input string tag);
        int k = 0;
        mk_cmd(8'h07, 32'd0);
        send(0, 1'b0);
        for (int c = 0; c < NWORDS + 10; c++) begin
            if (rd_valid) begin
                if (k < NWORDS) begin
                    chk(rd_data == exp_w[k], $sformatf("%s %s word %0d", tag, word_req(k), k),
                        rd_data, exp_w[k]);
                    chk(rd_last == (k == NWORDS - 1), $sformatf("%s R9 last flag word %0d", tag, k),
                        32'(rd_last), 32'(k == NWORDS - 1));
                end
                k++;
            end
            @(negedge clk);
        end
        chk(k == NWORDS, {tag, " R9 word count"}, 32'(k), 32'(NWORDS));
    endtask

    logic [31:0] fp_x;

    task automatic t_reset();
        chk(rd_valid == 1'b0, "R1 rd_valid after reset", 32'(rd_valid), 0);
        chk(rd_last == 1'b0, "R1 rd_last after reset", 32'(rd_last), 0);
        dump_check("R1 reset");
    endtask

    task automatic t_basic();
        mk_pkt(32'hC0A80001, 16'h0050, 10);
        fp_x = fp_of();
        cmd(8'h01, 32'hC0A80001);
        cmd(8'h03, 32'h00000050);
        cmd(8'h05, fp_x);
        pkt(32'hC0A80001, 16'h0050, 10);        // all three tables hit
        exp_w[2] += 1; exp_w[10] += 1; exp_w[18] += 1;
        pkt(32'h01020304, 16'h0050, 0);         // port only
        exp_w[10] += 1;
        mk_pkt(32'hC0A80001, 16'h0050, 0);      // 5-byte packet: address only (R5)
        plen = 5;
        send(3, 1'b0);
        exp_w[0] += 1; exp_w[1] += 5; exp_w[2] += 1;
        dump_check("basic R2 R3 R4 R5");
    endtask

    task automatic t_full();
        cmd(8'h01, 32'hC0A80001);               // duplicate (R7)
        for (int i = 1; i < 8; i++) cmd(8'h01, 32'h0B000000 + 32'(i));
        cmd(8'h01, 32'h0C000000);               // table full (R7)
        pkt(32'h0C000000, 16'h1111, 2);
        pkt(32'h0B000007, 16'h1111, 1);
        exp_w[2 + 7] += 1;
        pkt(32'hC0A80001, 16'h1111, 0);
        exp_w[2] += 1;
        dump_check("full R7");
    endtask

    task automatic t_delete();
        cmd(8'h02, 32'hC0A80001);               // slot 0 freed (R8)
        exp_w[2] = 0;
        cmd(8'h02, 32'h0D0D0D0D);               // absent key
        cmd(8'h04, 32'h00000050);
        exp_w[10] = 0;
        pkt(32'hC0A80001, 16'h0050, 3);         // no hits anymore
        mk_pkt(32'h0C000000, CPORT, 0);         // short control packet (R6)
        plen = 20;
        send(3, 1'b0);
        cmd(8'h01, 32'h0C000000);               // reuses slot 0 (R7)
        pkt(32'h0C000000, 16'h2222, 4);
        exp_w[2] += 1;
        dump_check("delete R8 R6");
    endtask

    task automatic t_burst();
        mk_pkt(32'h0C000000, 16'h3333, 1);      // R10: no idle between packets
        send(0, 1'b1);
        mk_pkt(32'h0B000003, 16'h3333, 2);
        send(0, 1'b1);
        mk_pkt(32'h0C000000, 16'h3333, 0);
        send(3, 1'b0);
        exp_w[0] += 3; exp_w[1] += 29 + 30 + 28;
        exp_w[2] += 2; exp_w[2 + 3] += 1;
        dump_check("burst R10");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < NWORDS; i++) exp_w[i] = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_full();
        t_delete();
        t_burst();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule